// File: doc/BRIEF.md
# Integer Execution Unit with Branch Condition Flags

This block is the arithmetic heart of a small 32-bit integer core. In a single evaluation it adds, subtracts, does signed and unsigned set-less-than, applies bitwise XOR, OR and AND, and shifts left, right logically or right arithmetically. The second operand comes either from a register or from an immediate that has already been sign-extended outside the block. The caller decides how the result is used: as a value written to a register, as a load or store address, or as a jump target. Decoding instructions and building immediates are left to the caller.

Next to the arithmetic path there is a separate comparison unit. It always compares the two register operands and produces all six branch conditions at once. Greater-or-equal is defined as the exact complement of less-than. A zero flag reports an all-zero result. The combinational work is captured in a single output register stage that has a synchronous, active-high reset, so every output appears one clock edge after its inputs are applied.

Top module: `alu_branch_unit`

## Requirements
- R1: Operation codes on `op_i` are: 0 add, 1 subtract, 2 signed set-less-than, 3 unsigned set-less-than, 4 XOR, 5 OR, 6 AND, 7 shift left, 8 logical shift right, 9 arithmetic shift right. Add and subtract wrap modulo 2^32 and ignore overflow.
- R2: Signed set-less-than gives 1 when rs1 is less than the second operand as two's-complement values, and 0 otherwise. The unsigned form compares both operands as unsigned numbers, including a sign-extended immediate. The upper 31 result bits are zero.
- R3: XOR, OR and AND act bit by bit between rs1 and the second operand.
- R4: Shifts use only bits [4:0] of the second operand as the amount. Left and logical right shifts fill with zeros. The arithmetic right shift fills with bit 31 of rs1.
- R5: When `use_imm_i` is 1 the second operand is `imm_i`; when it is 0 the second operand is `rs2_i`. The branch flags always compare `rs1_i` with `rs2_i`, whatever `use_imm_i` is.
- R6: The branch flags are equal, not-equal, signed less-than, signed greater-or-equal, unsigned less-than and unsigned greater-or-equal. Equal and not-equal are never both 1.
- R7: `ge_o` is always the inverse of `lt_o`, and `geu_o` is always the inverse of `ltu_o`.
- R8: `zero_o` is 1 exactly when `result_o` is all zeros.
- R9: Every output reflects the inputs sampled at the previous rising clock edge, and holds steady between edges.
- R10: While `rst` is high at a clock edge, the outputs go to: result 0, zero 1, eq 1, ne 0, lt 0, ge 1, ltu 0, geu 1.
- R11: Operation codes 10 to 15 give a result of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| use_imm_i | input | 1 | Selects the immediate as the second operand |
| rs1_i | input | 32 | First register operand |
| rs2_i | input | 32 | Second register operand |
| imm_i | input | 32 | Sign-extended immediate |
| result_o | output | 32 | Registered result |
| zero_o | output | 1 | Result is all zeros |
| eq_o | output | 1 | rs1 equals rs2 |
| ne_o | output | 1 | rs1 differs from rs2 |
| lt_o | output | 1 | rs1 less than rs2, signed |
| ge_o | output | 1 | rs1 greater or equal to rs2, signed |
| ltu_o | output | 1 | rs1 less than rs2, unsigned |
| geu_o | output | 1 | rs1 greater or equal to rs2, unsigned |

## Verification
Several corner cases are targeted:
- Adding past 2^32 must wrap to a small value. A design that kept a carry or saturated would give a large result.
- Comparing -1 with 1 tells signed from unsigned. A unit that mixed the two modes would give 1 for both set-less-than forms, or the wrong pair of branch flags.
- An all-ones immediate compared as unsigned must look larger than 5. A design that compared it as signed would return 0 here.
- Shifting by 31 separates sign fill from zero fill. A shift amount of 36 exposes a shifter that reads more than five bits, because it would produce zero instead of a shift by 4.
- Some vectors set `use_imm_i` while `rs2_i` holds a different value. These catch a wrong operand select, and a comparator that wrongly follows the immediate.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int XLEN = 32;
    localparam int SHW  = $clog2(XLEN);
    localparam int OPW  = 4;

    typedef logic [XLEN-1:0] word_t;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_SLT  = 4'd2,
        OP_SLTU = 4'd3,
        OP_XOR  = 4'd4,
        OP_OR   = 4'd5,
        OP_AND  = 4'd6,
        OP_SLL  = 4'd7,
        OP_SRL  = 4'd8,
        OP_SRA  = 4'd9
    } alu_op_e;

    typedef struct packed {
        logic eq;
        logic ne;
        logic lt;
        logic ge;
        logic ltu;
        logic geu;
    } br_flags_t;

    typedef struct packed {
        word_t     result;
        logic      zero;
        br_flags_t br;
    } alu_out_t;

    localparam br_flags_t FLAGS_RESET = '{eq: 1'b1, ne: 1'b0, lt: 1'b0,
                                          ge: 1'b1, ltu: 1'b0, geu: 1'b1};
    localparam alu_out_t  OUT_RESET   = '{result: '0, zero: 1'b1, br: FLAGS_RESET};

    // Mirror a word end to end, so the right shifter can also do left shifts.
    function automatic word_t bit_rev(input word_t v);
        word_t r;
        for (int i = 0; i < XLEN; i++) begin
            r[i] = v[XLEN-1-i];
        end
        return r;
    endfunction

    // Returns {signed less-than, unsigned less-than}. Both come from one
    // subtraction: the borrow out gives the unsigned order, and when the
    // sign bits differ the sign of rs1 decides the signed order.
    function automatic logic [1:0] less_pair(input word_t a, input word_t b);
        logic [XLEN:0] diff;
        logic          ltu_v;
        logic          lt_v;
        diff  = {1'b0, a} + {1'b0, ~b} + {{XLEN{1'b0}}, 1'b1};
        ltu_v = ~diff[XLEN];
        lt_v  = (a[XLEN-1] ^ b[XLEN-1]) ? a[XLEN-1] : ltu_v;
        return {lt_v, ltu_v};
    endfunction

endpackage

// File: rtl/alu_operand_sel.sv
module alu_operand_sel #(
    parameter int W = alu_pkg::XLEN
) (
    input  logic         use_imm,
    input  logic [W-1:0] rs2,
    input  logic [W-1:0] imm,
    output logic [W-1:0] opnd_b
);
    always_comb begin
        opnd_b = use_imm ? imm : rs2;
    end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
    parameter int W   = alu_pkg::XLEN,
    parameter int SHW = $clog2(W)
) (
    input  logic [W-1:0]   din,
    input  logic [SHW-1:0] amt,
    input  logic           left,
    input  logic           arith,
    output logic [W-1:0]   dout
);
    logic [W-1:0] stage [SHW+1];
    logic         fill;

    always_comb begin
        stage[0] = left ? alu_pkg::bit_rev(din) : din;
        fill     = arith & ~left & din[W-1];
    end

    // One stage per bit of the shift amount, each a fixed-distance 2:1 mux.
    for (genvar i = 0; i < SHW; i++) begin : g_stage
        localparam int DIST = 1 << i;
        always_comb begin
            stage[i+1] = amt[i] ? {{DIST{fill}}, stage[i][W-1:DIST]} : stage[i];
        end
    end

    always_comb begin
        dout = left ? alu_pkg::bit_rev(stage[SHW]) : stage[SHW];
    end
endmodule

// File: rtl/alu_core.sv
module alu_core #(
    parameter int W   = alu_pkg::XLEN,
    parameter int SHW = $clog2(W)
) (
    input  logic [alu_pkg::OPW-1:0] op,
    input  logic [W-1:0]            a,
    input  logic [W-1:0]            b,
    output logic [W-1:0]            result
);
    import alu_pkg::*;

    logic         is_sub;
    logic [W-1:0] sum;
    logic [1:0]   lt_pair;
    logic [W-1:0] sh_out;

    always_comb begin
        is_sub  = (op == OP_SUB);
        // One adder serves both add and subtract: invert b and carry in 1.
        sum     = a + (is_sub ? ~b : b) + {{(W-1){1'b0}}, is_sub};
        lt_pair = less_pair(a, b);
    end

    alu_shifter #(.W(W), .SHW(SHW)) u_shift (
        .din   (a),
        .amt   (b[SHW-1:0]),
        .left  (op == OP_SLL),
        .arith (op == OP_SRA),
        .dout  (sh_out)
    );

    always_comb begin
        case (op)
            OP_ADD, OP_SUB:         result = sum;
            OP_SLT:                 result = {{(W-1){1'b0}}, lt_pair[1]};
            OP_SLTU:                result = {{(W-1){1'b0}}, lt_pair[0]};
            OP_XOR:                 result = a ^ b;
            OP_OR:                  result = a | b;
            OP_AND:                 result = a & b;
            OP_SLL, OP_SRL, OP_SRA: result = sh_out;
            default:                result = '0;
        endcase
    end
endmodule

// File: rtl/alu_branch_cmp.sv
module alu_branch_cmp (
    input  alu_pkg::word_t     a,
    input  alu_pkg::word_t     b,
    output alu_pkg::br_flags_t flags
);
    logic [1:0] lt_pair;

    always_comb begin
        lt_pair   = alu_pkg::less_pair(a, b);
        flags.eq  = (a == b);
        flags.ne  = ~flags.eq;
        flags.lt  = lt_pair[1];
        flags.ge  = ~lt_pair[1];
        flags.ltu = lt_pair[0];
        flags.geu = ~lt_pair[0];
    end
endmodule

// File: rtl/alu_branch_unit.sv
module alu_branch_unit (
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  op_i,
    input  logic        use_imm_i,
    input  logic [31:0] rs1_i,
    input  logic [31:0] rs2_i,
    input  logic [31:0] imm_i,
    output logic [31:0] result_o,
    output logic        zero_o,
    output logic        eq_o,
    output logic        ne_o,
    output logic        lt_o,
    output logic        ge_o,
    output logic        ltu_o,
    output logic        geu_o
);
    import alu_pkg::*;

    word_t     opnd_b;
    word_t     res_c;
    br_flags_t br_c;
    alu_out_t  nxt;
    alu_out_t  q;

    alu_operand_sel #(.W(XLEN)) u_sel (
        .use_imm (use_imm_i),
        .rs2     (rs2_i),
        .imm     (imm_i),
        .opnd_b  (opnd_b)
    );

    alu_core #(.W(XLEN), .SHW(SHW)) u_core (
        .op     (op_i),
        .a      (rs1_i),
        .b      (opnd_b),
        .result (res_c)
    );

    alu_branch_cmp u_cmp (
        .a     (rs1_i),
        .b     (rs2_i),
        .flags (br_c)
    );

    always_comb begin
        nxt.result = res_c;
        nxt.zero   = ~|res_c;
        nxt.br     = br_c;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= OUT_RESET;
        end else begin
            q <= nxt;
        end
    end

    always_comb begin
        result_o = q.result;
        zero_o   = q.zero;
        eq_o     = q.br.eq;
        ne_o     = q.br.ne;
        lt_o     = q.br.lt;
        ge_o     = q.br.ge;
        ltu_o    = q.br.ltu;
        geu_o    = q.br.geu;
    end
endmodule

// File: rtl/alu_branch_unit_chk.sv
module alu_branch_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic [3:0]  op_i,
    input logic        use_imm_i,
    input logic [31:0] rs1_i,
    input logic [31:0] rs2_i,
    input logic [31:0] imm_i,
    input logic [31:0] result_o,
    input logic        zero_o,
    input logic        eq_o,
    input logic        ne_o,
    input logic        lt_o,
    input logic        ge_o,
    input logic        ltu_o,
    input logic        geu_o
);
    import alu_pkg::*;

    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
        zero_o == (result_o == 32'd0)); // R8
    AST_GE_SIGNED: assert property (@(posedge clk) disable iff (rst)
        ge_o == !lt_o); // R7
    AST_GE_UNSIGNED: assert property (@(posedge clk) disable iff (rst)
        geu_o == !ltu_o); // R7
    AST_EQ_NE_EXCL: assert property (@(posedge clk) disable iff (rst)
        eq_o != ne_o); // R6
    AST_EQ_TRACKS_REGS: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (eq_o == ($past(rs1_i) == $past(rs2_i)))); // R5
    AST_ADD_INVERSE: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'(OP_ADD)) |=>
        ((result_o - ($past(use_imm_i) ? $past(imm_i) : $past(rs2_i))) == $past(rs1_i))); // R1
    AST_SLT_NARROW: assert property (@(posedge clk) disable iff (rst)
        ((op_i == 4'(OP_SLT)) || (op_i == 4'(OP_SLTU))) |=> (result_o[31:1] == 31'd0)); // R2
    AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (rst)
        (op_i > 4'd9) |=> (result_o == 32'd0)); // R11
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (result_o == 32'd0 && zero_o && eq_o && !lt_o && !ltu_o)); // R10
endmodule

bind alu_branch_unit alu_branch_unit_chk u_chk (.*);

// File: tb/alu_branch_unit_tb.sv
module alu_branch_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op_i = '0;
    logic        use_imm_i = 1'b0;
    logic [31:0] rs1_i = '0;
    logic [31:0] rs2_i = '0;
    logic [31:0] imm_i = '0;
    logic [31:0] result_o;
    logic        zero_o, eq_o, ne_o, lt_o, ge_o, ltu_o, geu_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    alu_branch_unit u_dut (
        .clk, .rst, .op_i, .use_imm_i, .rs1_i, .rs2_i, .imm_i,
        .result_o, .zero_o, .eq_o, .ne_o, .lt_o, .ge_o, .ltu_o, .geu_o
    );

    // {op, use_imm, rs1, rs2, imm, expected result}
    localparam int NV = 17;
    localparam logic [132:0] VEC [NV] = '{
        {4'd0, 1'b0, 32'hFFFFFFFF, 32'h00000002, 32'h00000000, 32'h00000001}, // R1 wrap
        {4'd1, 1'b0, 32'h00000000, 32'h00000001, 32'h00000000, 32'hFFFFFFFF}, // R1 borrow
        {4'd1, 1'b0, 32'h12345678, 32'h12345678, 32'h00000000, 32'h00000000}, // R1 R8
        {4'd2, 1'b0, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 32'h00000001}, // R2 signed
        {4'd3, 1'b0, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 32'h00000000}, // R2 unsigned
        {4'd3, 1'b1, 32'h00000005, 32'h00000000, 32'hFFFFFFFF, 32'h00000001}, // R2 R5 imm unsigned
        {4'd2, 1'b1, 32'h00000005, 32'h00000009, 32'hFFFFFFFF, 32'h00000000}, // R2 R5 imm signed
        {4'd4, 1'b1, 32'hF0F0F0F0, 32'h00000000, 32'hFFFFF800, 32'h0F0F08F0}, // R3 xor
        {4'd5, 1'b0, 32'h00FF0000, 32'h0000FF00, 32'h00000000, 32'h00FFFF00}, // R3 or
        {4'd6, 1'b0, 32'h0F0F0F0F, 32'h33333333, 32'h00000000, 32'h03030303}, // R3 and
        {4'd7, 1'b0, 32'h00000001, 32'h00000024, 32'h00000000, 32'h00000010}, // R4 low 5 bits
        {4'd8, 1'b0, 32'h80000000, 32'h0000001F, 32'h00000000, 32'h00000001}, // R4 zero fill
        {4'd9, 1'b0, 32'h80000000, 32'h0000001F, 32'h00000000, 32'hFFFFFFFF}, // R4 sign fill
        {4'd9, 1'b0, 32'h7FFFFFF0, 32'h00000004, 32'h00000000, 32'h07FFFFFF}, // R4 positive
        {4'd8, 1'b1, 32'hF0000000, 32'h00000000, 32'h00000004, 32'h0F000000}, // R4 R5 imm
        {4'd12, 1'b0, 32'hDEADBEEF, 32'h00000003, 32'h00000000, 32'h00000000}, // R11
        {4'd0, 1'b1, 32'h00000010, 32'h80000000, 32'hFFFFFFF0, 32'h00000000}  // R5 R8
    };

    task automatic check_word(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] exp_flags(input logic [31:0] a, input logic [31:0] b,
                                             input logic [31:0] res);
        logic lt_s, lt_u;
        lt_s = $signed(a) < $signed(b);
        lt_u = a < b;
        return {res == 32'd0, a == b, a != b, lt_s, !lt_s, lt_u, !lt_u};
    endfunction

    function automatic logic [6:0] act_flags();
        return {zero_o, eq_o, ne_o, lt_o, ge_o, ltu_o, geu_o};
    endfunction

    task automatic apply(input logic [3:0] op, input logic ui, input logic [31:0] a,
                         input logic [31:0] b, input logic [31:0] im);
        op_i = op; use_imm_i = ui; rs1_i = a; rs2_i = b; imm_i = im;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R10: reset values
        @(posedge clk); #1;
        @(posedge clk); #1;
        check_word("R10 result", result_o, 32'd0);
        check_word("R10 flags", {25'd0, act_flags()}, {25'd0, 7'b1100101});
        rst = 1'b0;

        // Vector table: R1 R2 R3 R4 R5 R6 R7 R8 R11
        for (int i = 0; i < NV; i++) begin
            logic [132:0] v;
            v = VEC[i];
            apply(v[132:129], v[128], v[127:96], v[95:64], v[63:32]);
            check_word($sformatf("R1-table row %0d result", i), result_o, v[31:0]);
            check_word($sformatf("R6 R7 R8 row %0d flags", i), {25'd0, act_flags()},
                       {25'd0, exp_flags(v[127:96], v[95:64], v[31:0])});
        end

        // R6: equality and sign-boundary comparisons
        apply(4'd0, 1'b0, 32'h80000000, 32'h7FFFFFFF, 32'd0);
        check_word("R6 min vs max", {25'd0, act_flags()},
                   {25'd0, exp_flags(32'h80000000, 32'h7FFFFFFF, 32'hFFFFFFFF)});
        apply(4'd0, 1'b1, 32'h00000042, 32'h00000042, 32'h00000001);
        check_word("R6 equal regs", {25'd0, act_flags()},
                   {25'd0, exp_flags(32'h42, 32'h42, 32'h43)});

        // R9: output holds until the next edge
        apply(4'd0, 1'b0, 32'd7, 32'd8, 32'd0);
        op_i = 4'd1; rs1_i = 32'd100; rs2_i = 32'd1;
        #2;
        check_word("R9 hold before edge", result_o, 32'd15);
        @(posedge clk); #1;
        check_word("R9 update after edge", result_o, 32'd99);

        // R10: reset in mid run clears outputs
        apply(4'd5, 1'b0, 32'hAAAA0000, 32'h00005555, 32'd0);
        rst = 1'b1;
        @(posedge clk); #1;
        check_word("R10 mid-run result", result_o, 32'd0);
        check_word("R10 mid-run flags", {25'd0, act_flags()}, {25'd0, 7'b1100101});
        rst = 1'b0;
        apply(4'd0, 1'b0, 32'd1, 32'd2, 32'd0);
        check_word("R10 recovery", result_o, 32'd3);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule